// File: doc/BRIEF.md
# Learning Classifier Rule Table

This block holds a small set of learned rules for runtime self-optimization of one processor core. Each rule has a ternary condition over quantized monitor levels (operating frequency, utilization, workload), a 4-bit action code for the actuators and an 8-bit fitness score. When a monitor sample is accepted, all rules are compared with it in one cycle. The matching rule with the best fitness is chosen, and its action goes out to the frequency/voltage and task-migration logic.

A reward value then reinforces the rule that fired last. Its fitness moves a quarter of the way toward the reward, and the result is saturated. Over time this shapes which rule wins for a given operating point. A plain load port writes rules one per cycle.

The monitor samples come in and the decisions go out over valid/ready streams. A sample is accepted only while the decision register is empty or being drained (mon_ready = !act_valid || act_ready). A decision is held unchanged until act_ready takes it. The load port and the reward port are plain control pins with no handshake.

Top module: `lcs_rule_table`

## Requirements
- R1: After reset every rule slot is empty, act_valid is low, and no rule counts as having fired.
- R2: With load_en high, the slot at load_addr takes load_val, load_care, load_act and load_fit at that clock edge and becomes valid. A later load of the same slot replaces it.
- R3: Bits [2:0] of mon_level are the frequency level, [5:3] utilization and [8:6] workload. A valid slot matches when every bit with care=1 equals the monitor bit. A bit with care=0 matches anything. An empty slot never matches.
- R4: Among the matching slots the one with the highest fitness wins. On equal fitness the lowest index wins. act_rule and act_fit report the winning slot and its fitness.
- R5: When nothing matches, act_nomatch is 1 and act_code, act_rule and act_fit are 0.
- R6: A sample is accepted on an edge where mon_valid and mon_ready are both high, and its decision shows on the act outputs after that edge. While act_valid is high and act_ready is low, mon_ready is low and the decision outputs do not change.
- R7: With rew_valid high, the fitness f of the last fired slot becomes f + ((r - f) >>> 2), where r is the signed 8-bit rew_value. The shift is arithmetic and the result is clamped to 0..255. The new value is used from the next accepted sample on.
- R8: A reward has no effect if no sample has been accepted since reset, or if the last accepted sample matched nothing.
- R9: If a load and a reward hit the same slot in one cycle, the loaded fitness is kept. A sample accepted in the same cycle as a reward is judged with the fitness from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_valid | input | 1 | Monitor sample offered |
| mon_ready | output | 1 | Block can take a sample |
| mon_level | input | 9 | Quantized monitor levels, three 3-bit fields |
| act_valid | output | 1 | Decision available |
| act_ready | input | 1 | Actuators take the decision |
| act_code | output | 4 | Action code of the winning rule |
| act_nomatch | output | 1 | No rule matched the sample |
| act_rule | output | 4 | Index of the winning rule |
| act_fit | output | 8 | Fitness of the winning rule when chosen |
| rew_valid | input | 1 | Reward strobe |
| rew_value | input | 8 | Signed reward |
| load_en | input | 1 | Write one rule slot |
| load_addr | input | 4 | Slot to write |
| load_val | input | 9 | Condition value bits |
| load_care | input | 9 | Condition care mask (1 = compare) |
| load_act | input | 4 | Action code to store |
| load_fit | input | 8 | Initial fitness |

## Verification
The assertions assume that rst_n is held for at least one edge before traffic starts. They also assume that the actuator side never withdraws act_ready in a way that depends on act_code. The stimulus changes inputs only on falling edges. It drives the reward, load and sample pins one cycle at a time, except where a same-cycle conflict is itself the subject of a test. The sweeps cover all 512 monitor values against a fixed rule set, and a grid of fitness and reward values that includes both saturation limits.

// File: rtl/lcs_pkg.sv
package lcs_pkg;
  localparam int DEF_FIELDS   = 3;
  localparam int DEF_FIELD_W  = 3;
  localparam int DEF_ENTRIES  = 16;
  localparam int DEF_ACT_W    = 4;
  localparam int DEF_FIT_W    = 8;
  localparam int LEARN_SHIFT  = 2;
endpackage

// File: rtl/lcs_rule_store.sv
module lcs_rule_store #(
  parameter int ENTRIES = 16,
  parameter int COND_W  = 9,
  parameter int ACT_W   = 4,
  parameter int FIT_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            load_en,
  input  logic [IDX_W-1:0]                load_addr,
  input  logic [COND_W-1:0]               load_val,
  input  logic [COND_W-1:0]               load_care,
  input  logic [ACT_W-1:0]                load_act,
  input  logic [FIT_W-1:0]                load_fit,
  input  logic                            upd_en,
  input  logic [IDX_W-1:0]                upd_idx,
  input  logic [FIT_W-1:0]                upd_fit,
  output logic [ENTRIES-1:0]              ent_vld,
  output logic [ENTRIES-1:0][COND_W-1:0]  ent_val,
  output logic [ENTRIES-1:0][COND_W-1:0]  ent_care,
  output logic [ENTRIES-1:0][ACT_W-1:0]   ent_act,
  output logic [ENTRIES-1:0][FIT_W-1:0]   ent_fit
);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic hit_load, hit_upd;
    assign hit_load = load_en && (load_addr == IDX_W'(g));
    assign hit_upd  = upd_en  && (upd_idx  == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_vld[g]  <= 1'b0;
        ent_val[g]  <= '0;
        ent_care[g] <= '0;
        ent_act[g]  <= '0;
        ent_fit[g]  <= '0;
      end else if (hit_load) begin
        // a load wins over a reward aimed at the same slot
        ent_vld[g]  <= 1'b1;
        ent_val[g]  <= load_val;
        ent_care[g] <= load_care;
        ent_act[g]  <= load_act;
        ent_fit[g]  <= load_fit;
      end else if (hit_upd) begin
        ent_fit[g]  <= upd_fit;
      end
    end
  end

  assert_load_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ent_vld[$past(load_addr)] && ent_act[$past(load_addr)] == $past(load_act)
                && ent_care[$past(load_addr)] == $past(load_care));

  assert_load_beats_reward_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (load_en && upd_en && load_addr == upd_idx) |=> ent_fit[$past(load_addr)] == $past(load_fit));

endmodule

// File: rtl/lcs_match_select.sv
module lcs_match_select #(
  parameter int ENTRIES = 16,
  parameter int COND_W  = 9,
  parameter int ACT_W   = 4,
  parameter int FIT_W   = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [COND_W-1:0]               sample,
  input  logic [ENTRIES-1:0]              ent_vld,
  input  logic [ENTRIES-1:0][COND_W-1:0]  ent_val,
  input  logic [ENTRIES-1:0][COND_W-1:0]  ent_care,
  input  logic [ENTRIES-1:0][ACT_W-1:0]   ent_act,
  input  logic [ENTRIES-1:0][FIT_W-1:0]   ent_fit,
  output logic                            hit,
  output logic [IDX_W-1:0]                win_idx,
  output logic [ACT_W-1:0]                win_act,
  output logic [FIT_W-1:0]                win_fit
);

  logic [ENTRIES-1:0] match_vec;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    // ternary compare: only cared bits must agree
    assign match_vec[g] = ent_vld[g] && (((sample ^ ent_val[g]) & ent_care[g]) == '0);
  end

  always_comb begin
    hit     = 1'b0;
    win_idx = '0;
    win_fit = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      // strict compare keeps the lowest index on a tie
      if (match_vec[i] && (!hit || ent_fit[i] > win_fit)) begin
        hit     = 1'b1;
        win_idx = IDX_W'(i);
        win_fit = ent_fit[i];
      end
    end
    win_act = hit ? ent_act[win_idx] : '0;
  end

  assert_winner_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[win_idx] && ent_vld[win_idx]);

  assert_winner_top_fit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> ent_fit[win_idx] == win_fit);

endmodule

// File: rtl/lcs_fitness_update.sv
module lcs_fitness_update #(
  parameter int FIT_W = 8,
  parameter int SHIFT = 2
) (
  input  logic [FIT_W-1:0]        old_fit,
  input  logic signed [FIT_W-1:0] reward,
  output logic [FIT_W-1:0]        new_fit
);

  localparam int W = FIT_W + 2;
  localparam logic signed [W-1:0] MAXV = {2'b00, {FIT_W{1'b1}}};

  logic signed [W-1:0] old_s, rew_s, diff, step, sum;

  always_comb begin
    old_s = {2'b00, old_fit};
    rew_s = {{2{reward[FIT_W-1]}}, reward};
    diff  = rew_s - old_s;
    step  = diff >>> SHIFT;
    sum   = old_s + step;
    if (sum < 0)         new_fit = '0;
    else if (sum > MAXV) new_fit = '1;
    else                 new_fit = sum[FIT_W-1:0];
  end

endmodule

// File: rtl/lcs_rule_table.sv
module lcs_rule_table #(
  parameter int FIELDS  = lcs_pkg::DEF_FIELDS,
  parameter int FIELD_W = lcs_pkg::DEF_FIELD_W,
  parameter int ENTRIES = lcs_pkg::DEF_ENTRIES,
  parameter int ACT_W   = lcs_pkg::DEF_ACT_W,
  parameter int FIT_W   = lcs_pkg::DEF_FIT_W,
  localparam int COND_W = FIELDS * FIELD_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mon_valid,
  output logic                     mon_ready,
  input  logic [COND_W-1:0]        mon_level,
  output logic                     act_valid,
  input  logic                     act_ready,
  output logic [ACT_W-1:0]         act_code,
  output logic                     act_nomatch,
  output logic [IDX_W-1:0]         act_rule,
  output logic [FIT_W-1:0]         act_fit,
  input  logic                     rew_valid,
  input  logic signed [FIT_W-1:0]  rew_value,
  input  logic                     load_en,
  input  logic [IDX_W-1:0]         load_addr,
  input  logic [COND_W-1:0]        load_val,
  input  logic [COND_W-1:0]        load_care,
  input  logic [ACT_W-1:0]         load_act,
  input  logic [FIT_W-1:0]         load_fit
);

  logic [ENTRIES-1:0]              ent_vld;
  logic [ENTRIES-1:0][COND_W-1:0]  ent_val;
  logic [ENTRIES-1:0][COND_W-1:0]  ent_care;
  logic [ENTRIES-1:0][ACT_W-1:0]   ent_act;
  logic [ENTRIES-1:0][FIT_W-1:0]   ent_fit;

  logic             hit;
  logic [IDX_W-1:0] win_idx;
  logic [ACT_W-1:0] win_act;
  logic [FIT_W-1:0] win_fit;

  logic             last_ok;
  logic             ever_issued;
  logic [IDX_W-1:0] last_idx;
  logic             upd_en;
  logic [FIT_W-1:0] upd_fit;
  logic             accept;

  assign mon_ready = !act_valid || act_ready;
  assign accept    = mon_valid && mon_ready;
  assign upd_en    = rew_valid && last_ok;

  lcs_rule_store #(
    .ENTRIES(ENTRIES), .COND_W(COND_W), .ACT_W(ACT_W), .FIT_W(FIT_W)
  ) store_i (
    .clk(clk), .rst_n(rst_n),
    .load_en(load_en), .load_addr(load_addr), .load_val(load_val),
    .load_care(load_care), .load_act(load_act), .load_fit(load_fit),
    .upd_en(upd_en), .upd_idx(last_idx), .upd_fit(upd_fit),
    .ent_vld(ent_vld), .ent_val(ent_val), .ent_care(ent_care),
    .ent_act(ent_act), .ent_fit(ent_fit)
  );

  lcs_match_select #(
    .ENTRIES(ENTRIES), .COND_W(COND_W), .ACT_W(ACT_W), .FIT_W(FIT_W)
  ) select_i (
    .clk(clk), .rst_n(rst_n), .sample(mon_level),
    .ent_vld(ent_vld), .ent_val(ent_val), .ent_care(ent_care),
    .ent_act(ent_act), .ent_fit(ent_fit),
    .hit(hit), .win_idx(win_idx), .win_act(win_act), .win_fit(win_fit)
  );

  lcs_fitness_update #(
    .FIT_W(FIT_W), .SHIFT(lcs_pkg::LEARN_SHIFT)
  ) learn_i (
    .old_fit(ent_fit[last_idx]), .reward(rew_value), .new_fit(upd_fit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid   <= 1'b0;
      act_code    <= '0;
      act_nomatch <= 1'b0;
      act_rule    <= '0;
      act_fit     <= '0;
      last_idx    <= '0;
      last_ok     <= 1'b0;
      ever_issued <= 1'b0;
    end else if (accept) begin
      act_valid   <= 1'b1;
      act_code    <= win_act;
      act_nomatch <= !hit;
      act_rule    <= hit ? win_idx : '0;
      act_fit     <= hit ? win_fit : '0;
      last_idx    <= win_idx;
      last_ok     <= hit;
      ever_issued <= 1'b1;
    end else if (act_ready) begin
      act_valid   <= 1'b0;
    end
  end

  assert_hold_under_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready) |=> act_valid && $stable(act_code) && $stable(act_rule)
                                  && $stable(act_fit) && $stable(act_nomatch));

  assert_nomatch_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && act_nomatch) |-> act_code == '0 && act_fit == '0);

  assert_valid_after_issue_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid || last_ok) |-> ever_issued);

  assert_stall_blocks_input_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_valid && !act_ready && mon_valid) |=> $stable(act_rule));

endmodule

// File: tb/lcs_rule_table_tb.sv
module lcs_rule_table_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic       rst_n, mon_valid, mon_ready, act_valid, act_ready, act_nomatch;
  logic [8:0] mon_level, load_val, load_care;
  logic [3:0] act_code, act_rule, load_addr, load_act;
  logic [7:0] act_fit, load_fit;
  logic       rew_valid, load_en;
  logic signed [7:0] rew_value;

  lcs_rule_table dut_i (
    .clk(clk), .rst_n(rst_n), .mon_valid(mon_valid), .mon_ready(mon_ready),
    .mon_level(mon_level), .act_valid(act_valid), .act_ready(act_ready),
    .act_code(act_code), .act_nomatch(act_nomatch), .act_rule(act_rule),
    .act_fit(act_fit), .rew_valid(rew_valid), .rew_value(rew_value),
    .load_en(load_en), .load_addr(load_addr), .load_val(load_val),
    .load_care(load_care), .load_act(load_act), .load_fit(load_fit)
  );

  int n_checks = 0, n_fail = 0, cyc = 0;
  int m_vld[16], m_val[16], m_care[16], m_act[16], m_fit[16];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load(input int a, input int v, input int c, input int ac, input int f);
    @(negedge clk);
    load_en = 1; load_addr = 4'(a); load_val = 9'(v); load_care = 9'(c);
    load_act = 4'(ac); load_fit = 8'(f);
    @(negedge clk);
    load_en = 0;
    m_vld[a] = 1; m_val[a] = v & 511; m_care[a] = c & 511; m_act[a] = ac & 15; m_fit[a] = f & 255;
  endtask

  task automatic reward(input int r);
    @(negedge clk);
    rew_valid = 1; rew_value = 8'(r);
    @(negedge clk);
    rew_valid = 0;
  endtask

  // issue one sample and return at the negedge after acceptance
  task automatic issue(input int lvl);
    @(negedge clk);
    act_ready = 1; mon_valid = 1; mon_level = 9'(lvl);
    @(negedge clk);
    mon_valid = 0;
  endtask

  function automatic int upd(input int f, input int r);
    int s;
    s = f + ((r - f) >>> 2);
    if (s < 0) s = 0;
    if (s > 255) s = 255;
    return s;
  endfunction

  task automatic expect_decision(input int lvl, input string req);
    int best = -1;
    for (int i = 0; i < 16; i++)
      if (m_vld[i] != 0 && (((lvl ^ m_val[i]) & m_care[i]) == 0))
        if (best < 0 || m_fit[i] > m_fit[best]) best = i;
    if (best < 0) begin
      check(act_valid && act_nomatch && act_code == 0, req, {act_nomatch, act_code}, 16);
    end else begin
      check(act_valid && !act_nomatch && act_rule == 4'(best) && act_code == 4'(m_act[best])
            && act_fit == 8'(m_fit[best]), req, act_rule, best);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
    for (int i = 0; i < 16; i++) m_vld[i] = 0;
  endtask

  initial begin
    rst_n = 0; mon_valid = 0; mon_level = 0; act_ready = 1; rew_valid = 0; rew_value = 0;
    load_en = 0; load_addr = 0; load_val = 0; load_care = 0; load_act = 0; load_fit = 0;
    do_reset();

    // R1: reset state
    check(act_valid == 0, "R1 act_valid after reset", act_valid, 0);
    check(mon_ready == 1, "R1 mon_ready after reset", mon_ready, 1);
    issue(0);
    check(act_valid && act_nomatch && act_code == 0, "R1 empty table gives no match", act_nomatch, 1);

    // R8: reward before any issue is ignored
    do_reset();
    load(0, 0, 0, 5, 100);
    reward(127);
    issue(0);
    check(act_fit == 100, "R8 reward before first issue ignored", act_fit, 100);
    // R8: reward after a no-match issue is ignored
    do_reset();
    load(0, 0, 9'h1FF, 6, 100);
    issue(3);
    check(act_nomatch == 1, "R5 nomatch for unmatched sample", act_nomatch, 1);
    reward(127);
    issue(0);
    check(act_fit == 100 && act_code == 6, "R8 reward after no-match ignored", act_fit, 100);
    reward(127);
    issue(0);
    check(act_fit == 8'(upd(100, 127)), "R7 reward after match", act_fit, upd(100, 127));

    // R9: load beats reward on the same slot
    @(negedge clk);
    rew_valid = 1; rew_value = 8'sd127;
    load_en = 1; load_addr = 0; load_val = 0; load_care = 9'h1FF; load_act = 6; load_fit = 50;
    @(negedge clk);
    rew_valid = 0; load_en = 0; m_fit[0] = 50;
    issue(0);
    check(act_fit == 50, "R9 load wins over reward", act_fit, 50);
    // R9: sample in the same cycle as reward sees old fitness
    @(negedge clk);
    act_ready = 1; mon_valid = 1; mon_level = 0; rew_valid = 1; rew_value = -8'sd100;
    @(negedge clk);
    mon_valid = 0; rew_valid = 0;
    check(act_fit == 50, "R9 same-cycle sample uses old fitness", act_fit, 50);
    issue(0);
    check(act_fit == 8'(upd(50, -100)), "R9 update visible next sample", act_fit, upd(50, -100));

    // R6: back-pressure holds the decision and blocks input
    @(negedge clk);
    act_ready = 0; mon_valid = 1; mon_level = 0;
    @(negedge clk);
    mon_level = 9'h1FF;
    check(act_valid && !mon_ready, "R6 mon_ready low while stalled", mon_ready, 0);
    load(0, 0, 9'h1FF, 9, 77);
    mon_valid = 1;
    repeat (3) @(negedge clk);
    check(act_valid && act_code == 6 && act_fit == 8'(upd(50, -100)), "R6 decision held under stall",
          act_code, 6);
    mon_valid = 0; act_ready = 1;
    @(negedge clk);
    check(act_valid == 0, "R6 decision drained", act_valid, 0);

    // R7: fitness update grid including both saturation limits
    do_reset();
    for (int i = 1; i < 16; i++) load(i, 9'h1FF, 9'h1FF, i, 255);
    begin
      int fs[7] = '{0, 1, 64, 127, 128, 200, 255};
      int rs[6] = '{-128, -1, 0, 1, 50, 127};
      for (int a = 0; a < 7; a++)
        for (int b = 0; b < 6; b++) begin
          load(0, 0, 0, 3, fs[a]);
          issue(0);
          check(act_rule == 0 && act_fit == 8'(fs[a]), "R7 fitness before reward", act_fit, fs[a]);
          reward(rs[b]);
          issue(0);
          check(act_fit == 8'(upd(fs[a], rs[b])), "R7 fitness after reward", act_fit, upd(fs[a], rs[b]));
        end
    end

    // R3/R4/R5: exhaustive sweep of monitor levels over a fixed rule set
    do_reset();
    for (int i = 0; i < 16; i++)
      load(i, (i * 37 + 5), ((i * 53) & (i * 29 + 7)), 15 - i, ((i * 7) % 5) * 40);
    for (int lvl = 0; lvl < 512; lvl++) begin
      issue(lvl);
      expect_decision(lvl, "R3 sweep decision");
    end

    // R4: tie goes to the lower index; R2: reload replaces a slot
    do_reset();
    for (int i = 0; i < 16; i++) load(i, 9'h1FF, 9'h1FF, i, 255);
    load(3, 0, 0, 3, 200);
    load(7, 0, 0, 7, 200);
    issue(0);
    check(act_rule == 3 && act_code == 3, "R4 tie picks lowest index", act_rule, 3);
    load(3, 0, 0, 3, 199);
    issue(0);
    check(act_rule == 7 && act_fit == 200, "R2 reload replaces slot", act_rule, 7);
    load(7, 0, 9'h007, 11, 201);
    issue(9'h1F8);
    check(act_rule == 7 && act_code == 11, "R3 don't-care bits ignore monitor", act_rule, 7);
    issue(9'h1F9);
    check(act_rule == 3, "R3 cared bit mismatch excludes slot", act_rule, 3);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule